// File: doc/BRIEF.md
# Front-Panel Indicator Register Block

This block holds the configuration registers behind a front panel's indicators. Two bicolour status LEDs each get their own byte-wide register. The register selects a colour and a blink rate. The block turns that setting into separate red and green drive outputs and times the blinking itself from the system clock. A third register drives the seven segments and the decimal point of a numeric display directly. A read-only location returns the position of a 16-position rotary switch, which is first brought into the clock domain.

A host reaches the block through a byte-wide register bus with a write strobe, a read strobe and a small address. The default register map is:

| Address | Contents |
|---------|----------|
| 0 | first LED |
| 1 | second LED |
| 2 | segment register |
| 3 | rotary switch (read-only) |
| 4 to 7 | unmapped |

The LED count is a parameter. The segment and switch locations follow directly after the last LED address. The blink timing uses a single free-running quarter-second base, scaled by the `CLK_HZ` parameter. Because every LED uses that one base, all LEDs blink in step.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both LED registers and the segment register hold 0x00, and every LED and segment output is low.
- R2: A write to an LED address (0 or 1) stores all 8 bits in that register alone, at the clock edge that samples the strobe. A later read of that address returns the byte unchanged.
- R3: LED register bits 1:0 select the colour. 00 drives both outputs low, 01 drives green only, 10 drives red only, and 11 drives red and green together (yellow).
- R4: LED register bits 3:2 select the blink mode. 00 is steady (continuously lit), 01 is 0.5 Hz, 10 is 1 Hz and 11 is 2 Hz. Every mode has a 50% duty cycle, and both outputs are low in the dark half.
- R5: The blink base is a phase count that advances once every CLK_HZ/4 clock cycles, counted from reset release. With q = floor(cycles since release / (CLK_HZ/4)), the 0.5 Hz mode is lit while bit 2 of q is 0, the 1 Hz mode while bit 1 is 0, and the 2 Hz mode while bit 0 is 0. All LEDs share this one base.
- R6: A register write, including one that changes only the blink field, does not restart or shift the blink base.
- R7: Bits 7:4 of an LED register are kept and read back, but they have no effect on the LED outputs.
- R8: The segment register (address 2) drives segment A from bit 0, through segment G from bit 6, and the decimal point from bit 7. The outputs follow a write from the edge that samples it, and the register reads back as written.
- R9: Reading address 3 returns the rotary switch value in bits 3:0 and zero in bits 7:4. A switch change made before edge k is returned by a read sampled at edge k+2 or later, and reads sampled at edges k and k+1 return the old value. Writes to address 3 are ignored.
- R10: Read data is registered at the edge that samples the read strobe and holds until the next read. Reads of addresses 4 to 7 return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rot_sw | input | 4 | Asynchronous rotary switch position |
| led_red | output | NUM_LED | Red drive for each LED |
| led_grn | output | NUM_LED | Green drive for each LED |
| seg | output | 7 | Segments A (bit 0) to G (bit 6) |
| seg_dp | output | 1 | Decimal point |

## Verification
A register write is visible at the LED and segment outputs right after the edge that samples the strobe. The bench therefore compares those outputs on the falling edge that follows the write. Read data is due one edge after the strobe. Each read's expected byte is queued when the read is issued and compared on the falling edge after the sampling edge. Rotary switch values need two further edges, so the bench issues back-to-back reads at edges k, k+1 and k+2 and expects old, old, then new. The blink phase is predicted by a bench cycle counter started at reset release. Outputs are compared against it on every falling edge across whole blink periods, including after a write part-way through a phase.

// File: rtl/fp_pkg.sv
// Package: shared encodings for the front-panel indicator block.
// Assumes 8-bit registers; colour and blink codes are fixed by the host map.
package fp_pkg;
    localparam int REG_W   = 8;
    localparam int PHASE_W = 3;   // quarter-second ticks, 8 per 2 s period

    typedef enum logic [1:0] {
        COL_DARK   = 2'b00,
        COL_GREEN  = 2'b01,
        COL_RED    = 2'b10,
        COL_YELLOW = 2'b11
    } colour_e;

    typedef enum logic [1:0] {
        BLK_STEADY = 2'b00,
        BLK_SLOW   = 2'b01,   // 0.5 Hz
        BLK_MID    = 2'b10,   // 1 Hz
        BLK_FAST   = 2'b11    // 2 Hz
    } blink_e;
endpackage

// File: rtl/fp_prescaler.sv
// Module: free-running blink time base.
// Produces a phase count that advances every CLK_HZ/4 cycles (a quarter second).
// Assumes CLK_HZ >= 4; nothing but reset restarts it.
module fp_prescaler #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);
    localparam int QTR   = (CLK_HZ / 4 < 1) ? 1 : CLK_HZ / 4;
    localparam int CNT_W = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CNT_W-1:0] cnt;

    // Count cycles within a quarter second and step the phase at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= '0;
        end else if (cnt == CNT_W'(QTR - 1)) begin
            cnt   <= '0;
            phase <= phase + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fp_led_drive.sv
// Module: converts one LED register into red/green drive.
// Purely combinational; assumes phase comes from the shared prescaler.
// Bits 7:4 of the register are not looked at.
module fp_led_drive
    import fp_pkg::*;
(
    input  logic [3:0]         cfg,
    input  logic [PHASE_W-1:0] phase,
    output logic               red,
    output logic               grn
);
    colour_e colour;
    blink_e  blink;
    logic    lit;

    assign colour = colour_e'(cfg[1:0]);
    assign blink  = blink_e'(cfg[3:2]);

    // Decide whether the current phase is a lit half for the chosen rate.
    always_comb begin
        unique case (blink)
            BLK_STEADY: lit = 1'b1;
            BLK_SLOW:   lit = ~phase[2];
            BLK_MID:    lit = ~phase[1];
            BLK_FAST:   lit = ~phase[0];
        endcase
    end

    // Gate the colour onto the two drive lines.
    always_comb begin
        red = lit && (colour == COL_RED   || colour == COL_YELLOW);
        grn = lit && (colour == COL_GREEN || colour == COL_YELLOW);
    end
endmodule

// File: rtl/fp_sync2.sv
// Module: two-flop synchroniser for a slow asynchronous bus.
// Assumes the input changes rarely (a hand-turned switch), so bits need no grouping.
module fp_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fp_status_ctrl.sv
// Module: front-panel indicator register block (top).
// Holds NUM_LED LED registers, a segment register and a read-only switch port
// on a byte bus. LEDs are at addresses 0..NUM_LED-1, segments next, switch next.
// Assumes single-cycle strobes; read data is registered.
module fp_status_ctrl
    import fp_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int ADDR_W  = 3,
    parameter int NUM_LED = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    input  logic [3:0]         rot_sw,
    output logic [NUM_LED-1:0] led_red,
    output logic [NUM_LED-1:0] led_grn,
    output logic [6:0]         seg,
    output logic               seg_dp
);
    localparam int SEG_ADR = NUM_LED;
    localparam int ROT_ADR = NUM_LED + 1;

    logic [NUM_LED-1:0][REG_W-1:0] led_q;
    logic [REG_W-1:0]              seg_q;
    logic [PHASE_W-1:0]            blink_phase;
    logic [3:0]                    rot_s;
    logic [REG_W-1:0]              rd_mux;

    fp_prescaler #(.CLK_HZ(CLK_HZ), .PHASE_W(PHASE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    fp_sync2 #(.W(4)) u_rot_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rot_sw),
        .q     (rot_s)
    );

    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
        // Store this LED's register on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                led_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))
                led_q[i] <= wdata;
        end

        fp_led_drive u_drv (
            .cfg   (led_q[i][3:0]),
            .phase (blink_phase),
            .red   (led_red[i]),
            .grn   (led_grn[i])
        );
    end

    // Store the segment register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= '0;
        else if (wr_en && addr == ADDR_W'(SEG_ADR))
            seg_q <= wdata;
    end

    assign seg    = seg_q[6:0];
    assign seg_dp = seg_q[7];

    // Select read data by address; unmapped locations read zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_LED; i++)
            if (addr == ADDR_W'(i)) rd_mux = led_q[i];
        if (addr == ADDR_W'(SEG_ADR)) rd_mux = seg_q;
        if (addr == ADDR_W'(ROT_ADR)) rd_mux = {4'b0000, rot_s};
    end

    // Capture read data when the read strobe is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/fp_status_ctrl_chk.sv
// Module: property checker for fp_status_ctrl, attached by bind below.
// Assumes the default-style map: LEDs first, then segments, then the switch.
module fp_status_ctrl_chk #(
    parameter int ADDR_W  = 3,
    parameter int NUM_LED = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [7:0]                wdata,
    input logic [7:0]                rdata,
    input logic [NUM_LED-1:0]        led_red,
    input logic [NUM_LED-1:0]        led_grn,
    input logic [6:0]                seg,
    input logic                      seg_dp,
    input logic [NUM_LED-1:0][7:0]   led_q,
    input logic [2:0]                blink_phase
);
    localparam int SEG_ADR = NUM_LED;
    localparam int ROT_ADR = NUM_LED + 1;

    AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(SEG_ADR)) |=> ({seg_dp, seg} == $past(wdata))); // R8

    AST_ROT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ROT_ADR)) |=> (rdata[7:4] == 4'b0000)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) > ROT_ADR) |=> (rdata == 8'h00)); // R10

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_phase != $past(blink_phase)) |-> (blink_phase == 3'($past(blink_phase) + 1))); // R5

    for (genvar i = 0; i < NUM_LED; i++) begin : g_chk
        AST_LED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(i)) |=> (led_q[i] == $past(wdata))); // R2

        AST_DARK_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
            (led_q[i][1:0] == 2'b00) |-> (!led_red[i] && !led_grn[i])); // R3

        AST_YELLOW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            (led_q[i][3:0] == 4'b0011) |-> (led_red[i] && led_grn[i])); // R3

        AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (led_q[i][3:2] == 2'b00 && $stable(led_q[i]))
                |-> ($stable(led_red[i]) && $stable(led_grn[i]))); // R4
    end
endmodule

bind fp_status_ctrl fp_status_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_LED(NUM_LED)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .led_red     (led_red),
    .led_grn     (led_grn),
    .seg         (seg),
    .seg_dp      (seg_dp),
    .led_q       (led_q),
    .blink_phase (blink_phase)
);

// File: tb/fp_status_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard for fp_status_ctrl. Reads queue expected bytes, a monitor
// compares them; LED outputs are compared against a cycle-count model.
module fp_status_ctrl_tb_top;
    localparam int CLK_HZ = 40;
    localparam int QTR    = CLK_HZ / 4;
    localparam int ADDR_W = 3;
    localparam int NL     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic [3:0]        rot_sw = 4'h0;
    logic [NL-1:0]     led_red, led_grn;
    logic [6:0]        seg;
    logic              seg_dp;

    int n_chk = 0, n_fail = 0;
    int tcnt = 0, wd = 0;
    bit done = 0;
    logic [7:0] m_led [NL];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    fp_status_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .NUM_LED(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rot_sw(rot_sw), .led_red(led_red),
        .led_grn(led_grn), .seg(seg), .seg_dp(seg_dp)
    );

    always #2.5 clk = ~clk;

    // Cycles since reset release, the bench's own blink base.
    always @(posedge clk) tcnt <= rst_n ? tcnt + 1 : 0;
    always @(posedge clk) rd_seen <= rd_en;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare registered read data one edge after the strobe.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
        end
    end

    function automatic logic [1:0] exp_rg(logic [7:0] r, int t);
        int  ph = (t / QTR) % 8;
        logic lit;
        case (r[3:2])
            2'b00: lit = 1'b1;
            2'b01: lit = ((ph >> 2) & 1) == 0;
            2'b10: lit = ((ph >> 1) & 1) == 0;
            default: lit = (ph & 1) == 0;
        endcase
        return {lit & r[1], lit & r[0]};
    endfunction

    task automatic do_write(int a, logic [7:0] d);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < NL) m_led[a] = d;
    endtask

    task automatic do_read(int a, logic [7:0] e, string tag);
        rd_en = 1'b1; addr = ADDR_W'(a);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic led_window(int n, string tag);
        for (int c = 0; c < n; c++) begin
            for (int i = 0; i < NL; i++) begin
                logic [1:0] e = exp_rg(m_led[i], tcnt);
                check(tag, {30'h0, led_red[i], led_grn[i]}, {30'h0, e});
            end
            @(negedge clk);
        end
    endtask

    // Watchdog: end a hung run as a failure.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) m_led[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {20'h0, led_red, led_grn, seg, seg_dp}, 32'h0);
        rst_n = 1'b1;
        check("R1 outputs after release", {20'h0, led_red, led_grn, seg, seg_dp}, 32'h0);
        do_read(0, 8'h00, "R1 led0 reset");
        do_read(1, 8'h00, "R1 led1 reset");
        do_read(2, 8'h00, "R1 seg reset");

        // Colours, steady.
        do_write(0, 8'h01);
        do_write(1, 8'h02);
        led_window(20, "R3 green/red steady");
        do_read(0, 8'h01, "R2 led0 readback");
        do_read(1, 8'h02, "R2 led1 readback");
        do_write(1, 8'h03);
        led_window(20, "R3 yellow steady");
        do_write(0, 8'h00);
        led_window(20, "R3 dark");

        // Blink rates on a shared base.
        do_write(0, 8'h05);
        do_write(1, 8'h0B);
        led_window(170, "R4 R5 slow and mid blink");
        do_write(0, 8'h0E);
        led_window(3, "R4 fast blink");
        do_write(0, 8'h06);
        led_window(100, "R6 blink change keeps base");

        // Upper bits ignored by outputs.
        do_write(0, 8'hF5);
        do_write(1, 8'hA0);
        led_window(90, "R7 upper bits no effect");
        do_read(0, 8'hF5, "R7 led0 upper bits kept");
        do_read(1, 8'hA0, "R7 led1 upper bits kept");

        // Segment register.
        do_write(2, 8'h7F);
        check("R8 segments A-G", {24'h0, seg_dp, seg}, 32'h7F);
        do_write(2, 8'h80);
        check("R8 decimal point", {24'h0, seg_dp, seg}, 32'h80);
        do_write(2, 8'h3C);
        check("R8 mixed segments", {24'h0, seg_dp, seg}, 32'h3C);
        do_read(2, 8'h3C, "R8 seg readback");

        // Rotary switch synchroniser latency.
        rot_sw = 4'h9;
        repeat (4) @(negedge clk);
        do_read(3, 8'h09, "R9 switch value");
        rot_sw = 4'h6;
        do_read(3, 8'h09, "R9 edge k old");
        do_read(3, 8'h09, "R9 edge k+1 old");
        do_read(3, 8'h06, "R9 edge k+2 new");
        do_write(3, 8'hAA);
        do_read(3, 8'h06, "R9 write ignored");

        // Unmapped space.
        do_write(5, 8'hFF);
        do_read(5, 8'h00, "R10 unmapped read");
        do_read(7, 8'h00, "R10 unmapped read top");
        do_read(0, 8'hF5, "R10 led0 untouched");
        do_read(1, 8'hA0, "R10 led1 untouched");
        do_read(2, 8'h3C, "R10 seg untouched");
        @(negedge clk);
        check("R10 rdata held", {24'h0, rdata}, 32'h3C);
        repeat (2) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule